// File: doc/BRIEF.md
# Asymmetric Decoder Steering Unit

The unit sits between an instruction buffer and a set of decoders of unequal strength. Each cycle the buffer offers up to three instructions whose boundaries are already known. For every slot it supplies a valid bit and the number of micro-ops that instruction needs. The unit chooses which of those instructions go to which decoder this cycle. It reports straight back to the buffer how many instructions were taken, and one cycle later it reports which decoders were loaded and how many micro-ops came out.

There is one strong decoder that can produce up to four micro-ops and two weak decoders that produce exactly one each. Steering keeps program order. Only the oldest offered instruction can reach the strong decoder. A younger instruction that needs more than one micro-op is not moved forward or swapped. It is held for a later cycle, and it stops everything behind it. An oldest instruction that needs more than four micro-ops goes to a microsequencer. The microsequencer emits four micro-ops per cycle until the instruction is finished, and no other instruction is decoded while it runs.

Top module: `steer_unit`

## Requirements
- R1: While `rst` is high, `take_cnt` is 0. On the clock edges where `rst` is high, every registered output (`dec_cplx`, `dec_simp`, `dec_useq`, `uop_total`) is cleared to 0.
- R2: When the microsequencer is idle and slot 0 is valid with a count of 1 to 4, that instruction is taken and goes to the strong decoder (`dec_cplx`=1). It adds its own count to `uop_total`.
- R3: Slot k (k = 1 or 2) is taken by weak decoder k-1 (`dec_simp` bit k-1) only when it is valid, needs exactly 1 micro-op, and slots 0 to k-1 were all taken in the same cycle. `take_cnt` counts the instructions taken, which always form a run starting at slot 0.
- R4: A valid instruction in slot 1 or 2 whose count is greater than 1 is not taken in that cycle. No younger slot is taken either, even one that needs only 1 micro-op.
- R5: If slot 0 is invalid, nothing is taken and no decoder is loaded, whatever the younger slots hold.
- R6: When the microsequencer is idle and slot 0 is valid with a count n greater than 4, only that instruction is taken. `dec_useq` is 1 for ceil(n/4) consecutive cycles. In each of those cycles `uop_total` is 4, except the last cycle, which carries the remainder (1 to 4).
- R7: In the cycles after the one in which a microsequenced instruction was taken, while micro-ops of it remain, `take_cnt` is 0. No decoder other than the microsequencer is loaded in those cycles.
- R8: `uop_total` never exceeds 6 in any cycle.
- R9: `take_cnt` depends combinationally on the slot inputs of the same cycle. `dec_cplx`, `dec_simp`, `dec_useq` and `uop_total` describe the decisions of the previous cycle.
- R10: The micro-op count is an unsigned 5-bit field per slot, with slot k at bits [5k+4:5k] of `slot_cnt`. A valid slot with count 0 is steered and counted exactly like a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | 3 | Valid bit per slot; bit 0 is the oldest instruction |
| slot_cnt | input | 15 | Micro-op count per slot, 5 bits each, slot 0 in the low bits |
| take_cnt | output | 2 | Instructions consumed this cycle (0 to 3), sent back to the buffer |
| dec_cplx | output | 1 | Strong decoder was loaded in the previous cycle |
| dec_simp | output | 2 | Weak decoders loaded in the previous cycle (bit 0 holds slot 1, bit 1 holds slot 2) |
| dec_useq | output | 1 | Microsequencer emitted micro-ops in the previous cycle |
| uop_total | output | 3 | Micro-ops produced in the previous cycle |

## Verification
`take_cnt` is due in the same cycle as the slot inputs. The bench drives the inputs on the falling edge and compares `take_cnt` a nanosecond later, before the next rising edge can register anything. The decoder flags and the micro-op total are due one rising edge later. The bench therefore compares them at the following falling edge, against the expectation it stored for the previous input set. A microsequenced instruction is followed across its whole run. The bench keeps a behavioural count of the remaining micro-ops and offers fresh instructions in the busy cycles, so that any instruction wrongly taken in those cycles shows up in `take_cnt`.

// File: rtl/steer_pkg.sv
package steer_pkg;

  // Destination chosen for one buffer slot in the current cycle
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_CPLX = 2'd1,
    ROUTE_SIMP = 2'd2,
    ROUTE_USEQ = 2'd3
  } route_e;

endpackage

// File: rtl/steer_pick.sv
// Combinational group selection: in-order, strength-aware
module steer_pick #(
  parameter int NSIMP    = 2,
  parameter int CW       = 5,
  parameter int CPLX_MAX = 4,
  localparam int NS      = NSIMP + 1,
  localparam int TW      = $clog2(NS + 1)
) (
  input  logic                   busy,
  input  logic [NS-1:0]          vld,
  input  logic [NS*CW-1:0]       cnt,
  output steer_pkg::route_e      route [NS],
  output logic [CW-1:0]          lead_cnt,
  output logic [TW-1:0]          take
);
  import steer_pkg::*;

  logic [CW-1:0] eff [NS];
  logic [NS-1:0] go;
  logic [NS-1:0] cont;

  // A zero count behaves as a single micro-op
  generate
    for (genvar k = 0; k < NS; k++) begin : g_eff
      assign eff[k] = (cnt[k*CW +: CW] == '0) ? CW'(1) : cnt[k*CW +: CW];
    end
  endgenerate

  assign lead_cnt = eff[0];

  // Oldest slot: strong decoder or microsequencer
  assign go[0]   = vld[0] && !busy;
  assign cont[0] = go[0] && (eff[0] <= CW'(CPLX_MAX));
  assign route[0] = !go[0]  ? ROUTE_NONE :
                    cont[0] ? ROUTE_CPLX : ROUTE_USEQ;

  // Younger slots: single-micro-op only, and only behind a taken run
  generate
    for (genvar k = 1; k < NS; k++) begin : g_young
      assign go[k]    = cont[k-1] && vld[k] && (eff[k] == CW'(1));
      assign cont[k]  = go[k];
      assign route[k] = go[k] ? ROUTE_SIMP : ROUTE_NONE;
    end
  endgenerate

  assign take = TW'($countones(go));

endmodule

// File: rtl/steer_useq.sv
// Microsequencer occupancy: emits RATE micro-ops per cycle
module steer_useq #(
  parameter int CW   = 5,
  parameter int RATE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] start_cnt,
  output logic          busy,
  output logic [CW-1:0] emit
);
  logic [CW-1:0] rem;

  assign busy = (rem != '0);
  assign emit = (rem > CW'(RATE)) ? CW'(RATE) : rem;

  always_ff @(posedge clk) begin
    if (rst)        rem <= '0;
    else if (start) rem <= start_cnt - CW'(RATE);
    else if (busy)  rem <= rem - emit;
  end

endmodule

// File: rtl/steer_unit.sv
module steer_unit #(
  parameter int NSIMP     = 2,
  parameter int CW        = 5,
  parameter int CPLX_MAX  = 4,
  parameter int USEQ_RATE = 4,
  localparam int NS       = NSIMP + 1,
  localparam int TW       = $clog2(NS + 1),
  localparam int PEAK     = ((CPLX_MAX > USEQ_RATE) ? CPLX_MAX : USEQ_RATE) + NSIMP,
  localparam int UW       = $clog2(PEAK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NS-1:0]    slot_vld,
  input  logic [NS*CW-1:0] slot_cnt,
  output logic [TW-1:0]    take_cnt,
  output logic             dec_cplx,
  output logic [NSIMP-1:0] dec_simp,
  output logic             dec_useq,
  output logic [UW-1:0]    uop_total
);
  import steer_pkg::*;

  route_e        route [NS];
  logic [CW-1:0] lead_cnt;
  logic [TW-1:0] take_raw;
  logic          useq_busy;
  logic [CW-1:0] useq_emit;
  logic          useq_start;

  steer_pick #(.NSIMP(NSIMP), .CW(CW), .CPLX_MAX(CPLX_MAX)) u_pick (
    .busy     (useq_busy),
    .vld      (slot_vld),
    .cnt      (slot_cnt),
    .route    (route),
    .lead_cnt (lead_cnt),
    .take     (take_raw)
  );

  assign useq_start = (route[0] == ROUTE_USEQ) && !rst;

  steer_useq #(.CW(CW), .RATE(USEQ_RATE)) u_useq (
    .clk       (clk),
    .rst       (rst),
    .start     (useq_start),
    .start_cnt (lead_cnt),
    .busy      (useq_busy),
    .emit      (useq_emit)
  );

  assign take_cnt = rst ? '0 : take_raw;

  // Next-cycle view of this cycle's decisions
  logic             nx_cplx;
  logic [NSIMP-1:0] nx_simp;
  logic             nx_useq;
  logic [UW-1:0]    nx_uops;

  generate
    for (genvar k = 0; k < NSIMP; k++) begin : g_simp
      assign nx_simp[k] = (route[k+1] == ROUTE_SIMP);
    end
  endgenerate

  assign nx_cplx = (route[0] == ROUTE_CPLX);
  assign nx_useq = useq_start || useq_busy;

  always_comb begin
    nx_uops = UW'($countones(nx_simp));
    if (nx_cplx)    nx_uops = nx_uops + UW'(lead_cnt);
    if (useq_start) nx_uops = nx_uops + UW'(USEQ_RATE);
    if (useq_busy)  nx_uops = nx_uops + UW'(useq_emit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_cplx  <= 1'b0;
      dec_simp  <= '0;
      dec_useq  <= 1'b0;
      uop_total <= '0;
    end else begin
      dec_cplx  <= nx_cplx;
      dec_simp  <= nx_simp;
      dec_useq  <= nx_useq;
      uop_total <= nx_uops;
    end
  end

endmodule

// File: rtl/steer_unit_chk.sv
module steer_unit_chk #(
  parameter int NSIMP = 2,
  parameter int TW    = 2,
  parameter int UW    = 3,
  parameter int PEAK  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [TW-1:0]    take_cnt,
  input logic             dec_cplx,
  input logic [NSIMP-1:0] dec_simp,
  input logic             dec_useq,
  input logic [UW-1:0]    uop_total,
  input logic             useq_busy
);

  p_uop_cap_r8: assert property (@(posedge clk) disable iff (rst)
    uop_total <= UW'(PEAK));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    useq_busy |-> take_cnt == '0);

  p_busy_emit_r6: assert property (@(posedge clk) disable iff (rst)
    useq_busy |=> dec_useq);

  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(dec_cplx && dec_useq));

  p_simp_behind_r3: assert property (@(posedge clk) disable iff (rst)
    (dec_simp != '0) |-> dec_cplx);

  p_take_lands_r9: assert property (@(posedge clk) disable iff (rst)
    (take_cnt != '0) |=> (dec_cplx || dec_useq));

endmodule

bind steer_unit steer_unit_chk #(
  .NSIMP(NSIMP), .TW(TW), .UW(UW), .PEAK(PEAK)
) u_chk (.*);

// File: tb/steer_unit_tb.sv
`timescale 1ns/1ps
module steer_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  slot_vld = '0;
  logic [14:0] slot_cnt = '0;
  logic [1:0]  take_cnt;
  logic        dec_cplx;
  logic [1:0]  dec_simp;
  logic        dec_useq;
  logic [2:0]  uop_total;

  int n_chk = 0;
  int n_bad = 0;
  int rem   = 0;   // model: micro-ops still owed by the microsequencer

  always #2.5 clk = ~clk;

  steer_unit u_dut (
    .clk(clk), .rst(rst), .slot_vld(slot_vld), .slot_cnt(slot_cnt),
    .take_cnt(take_cnt), .dec_cplx(dec_cplx), .dec_simp(dec_simp),
    .dec_useq(dec_useq), .uop_total(uop_total)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive, check same-cycle take, check registered results next cycle
  task automatic step(input logic [2:0] v, input int c0, input int c1, input int c2,
                      input string tag);
    int cs[3];
    int e_take, e_cplx, e_simp, e_useq, e_uops;
    bit run;
    cs[0] = c0; cs[1] = c1; cs[2] = c2;
    slot_vld = v;
    slot_cnt = {5'(c2), 5'(c1), 5'(c0)};
    #1;
    e_take = 0; e_cplx = 0; e_simp = 0; e_useq = 0; e_uops = 0;
    if (rem > 0) begin
      e_useq = 1;
      e_uops = (rem > 4) ? 4 : rem;
      rem    = rem - e_uops;
    end else if (v[0]) begin
      int n0;
      n0 = (cs[0] == 0) ? 1 : cs[0];
      e_take = 1;
      if (n0 > 4) begin
        e_useq = 1; e_uops = 4; rem = n0 - 4;
      end else begin
        e_cplx = 1; e_uops = n0; run = 1'b1;
        for (int k = 1; k < 3; k++) begin
          int nk;
          nk = (cs[k] == 0) ? 1 : cs[k];
          if (run && v[k] && nk == 1) begin
            e_take++; e_simp |= (1 << (k - 1)); e_uops++;
          end else run = 1'b0;
        end
      end
    end
    check({tag, "/R9"}, "take_cnt", int'(take_cnt), e_take);
    @(negedge clk);
    check(tag, "dec_cplx",  int'(dec_cplx),  e_cplx);
    check(tag, "dec_simp",  int'(dec_simp),  e_simp);
    check(tag, "dec_useq",  int'(dec_useq),  e_useq);
    check(tag, "uop_total", int'(uop_total), e_uops);
    if (uop_total > 3'd6) check("R8", "uop cap", int'(uop_total), 6);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset behaviour with busy-looking inputs
    slot_vld = 3'b111; slot_cnt = {5'd1, 5'd1, 5'd9};
    repeat (3) @(negedge clk);
    check("R1", "take_cnt in reset", int'(take_cnt), 0);
    check("R1", "dec_cplx", int'(dec_cplx), 0);
    check("R1", "dec_simp", int'(dec_simp), 0);
    check("R1", "dec_useq", int'(dec_useq), 0);
    check("R1", "uop_total", int'(uop_total), 0);
    rst = 1'b0;

    step(3'b000, 1, 1, 1, "R5");
    step(3'b110, 1, 1, 1, "R5");
    step(3'b001, 3, 1, 1, "R2");
    step(3'b001, 4, 0, 0, "R2");
    step(3'b111, 2, 1, 1, "R3");
    step(3'b111, 1, 1, 1, "R3");
    step(3'b101, 1, 1, 1, "R3");
    step(3'b111, 4, 1, 1, "R8");
    step(3'b111, 1, 2, 1, "R4");
    step(3'b111, 1, 1, 3, "R4");
    step(3'b111, 0, 0, 1, "R10");
    step(3'b111, 0, 0, 0, "R10");
    step(3'b111, 9, 1, 1, "R6");
    step(3'b111, 1, 1, 1, "R7");
    step(3'b111, 1, 1, 1, "R7");
    step(3'b111, 1, 1, 1, "R6");
    step(3'b001, 8, 0, 0, "R6");
    step(3'b111, 2, 1, 1, "R7");
    step(3'b001, 5, 0, 0, "R6");
    step(3'b011, 1, 1, 0, "R7");
    step(3'b001, 31, 0, 0, "R6");
    for (int i = 0; i < 9; i++) step(3'b111, 1, 1, 1, "R7");

    for (int i = 0; i < 4000; i++) begin
      int c[3];
      for (int k = 0; k < 3; k++)
        c[k] = ($urandom % 4 == 0) ? int'($urandom % 32) : int'($urandom % 3);
      step(3'($urandom), c[0], c[1], c[2], "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule